// File: doc/BRIEF.md
# SMBus Write Command Decoder

This block sits behind a bit-level SMBus slave that has already framed the bus traffic. That slave reports start and stop conditions and hands over each received byte, including the address byte. The decoder turns each write transaction into an action. A send-byte transaction loads the read pointer. A write-byte transaction to the volatile range becomes one register-file write. A write-word transaction loads a 16-bit pointer into the nonvolatile store. A reserved command code starts a page erase, but only if a configuration bit has enabled it.

The decoder decides ACK or NACK for every accepted byte and reports it to the bit-level engine one cycle later. Bytes arrive over a valid/ready stream. The decoder holds `rx_ready_o` low while a register-file write is waiting on `reg_wr_ready_i`, so the upstream engine must keep the byte and its valid stable until ready returns. A register write request stays valid, with stable address and data, until the register file accepts it. A transaction takes effect only at its stop, except for the erase, which starts as soon as its command byte arrives. While the store reports an erase in progress, the decoder does not acknowledge its own address.

Top module: `smbus_cmd_decoder`

## Requirements
- R1: The first byte after a start is the address byte: bits 7:1 hold the slave address and bit 0 is the read/write flag, with 0 meaning write. A write to the matching address with no erase in progress is ACKed. A mismatched address is NACKed (`ack_o` = 0), and every later byte of that transaction is NACKed and has no effect.
- R2: While `erase_busy_i` is 1, an address byte is NACKed even if it matches, and the rest of that transaction has no effect.
- R3: A write transaction that has a command byte and no data byte before the stop loads `ptr_o` with the command byte. This applies to every command byte except the erase code 0xFE.
- R4: A command byte in 0x00..0xDF followed by exactly one data byte and then a stop issues one register write. Its address is the command byte and its data is the data byte. The request becomes visible the cycle after the stop.
- R5: A command byte in 0xE0..0xFF other than 0xFE, followed by exactly two data bytes and then a stop, loads `nv_ptr_o` with {first data byte, second data byte}.
- R6: Command 0xFE, with erase enabled and no erase in progress, raises `erase_req_o` for one cycle, the cycle after the command byte is accepted. `erase_page_o` then gives bits 9:5 of `nv_ptr_o`. The command byte is ACKed and any further data byte in that transaction is NACKed.
- R7: Erase is enabled when bit 2 of the last data byte written to register 0x90 is 1. Reset clears the enable. With the enable clear, command 0xFE has no effect.
- R8: A stop that arrives before the expected data count leaves the register file and `nv_ptr_o` unchanged. A data byte beyond the expected count is NACKed and cancels the whole transaction.
- R9: While `reg_wr_valid_o` is 1 and `reg_wr_ready_i` is 0, the request, its address and its data stay stable, and `rx_ready_o` is 0.
- R10: After reset the following outputs are all 0: `ack_valid_o`, `erase_req_o`, `reg_wr_valid_o`, `ptr_o` and `nv_ptr_o`. `rx_ready_o` is 1 after reset.
- R11: `ack_valid_o` pulses exactly once, the cycle after each accepted byte and at no other time. Command bytes and in-range data bytes of a live transaction are ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Decoder can take a byte |
| rx_data_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | ACK decision valid for the last accepted byte |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| erase_busy_i | input | 1 | Nonvolatile store is erasing a page |
| reg_wr_valid_o | output | 1 | Register-file write request |
| reg_wr_ready_i | input | 1 | Register file accepts the request |
| reg_wr_addr_o | output | 8 | Register write address |
| reg_wr_data_o | output | 8 | Register write data |
| ptr_o | output | 8 | Read/block pointer |
| nv_ptr_o | output | 16 | Nonvolatile address pointer |
| erase_req_o | output | 1 | Page erase start pulse |
| erase_page_o | output | 5 | Page to erase |

## Verification
The assertions assume that the upstream engine sends start and stop as single-cycle pulses, never in the same cycle. They also assume that it holds a byte with its valid until the decoder is ready, and that `erase_busy_i` comes only from the store. The stimulus changes inputs only on the falling clock edge, issues each start or stop for exactly one cycle, and holds `rx_valid_i` until a rising edge at which `rx_ready_o` was seen high. It drives `erase_busy_i` by hand only between transactions.

// File: rtl/smbus_dec_pkg.sv
package smbus_dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_DROP
  } txn_state_e;

  typedef enum logic [1:0] {
    CLS_RAM, CLS_NV, CLS_ERASE
  } cmd_class_e;
endpackage

// File: rtl/sdec_classify.sv
module sdec_classify
  import smbus_dec_pkg::*;
#(
  parameter logic [7:0] RAM_TOP   = 8'hDF,
  parameter logic [7:0] ERASE_CMD = 8'hFE
) (
  input  logic [7:0]  cmd_i,
  output cmd_class_e  cls_o
);
  always_comb begin
    if (cmd_i == ERASE_CMD)     cls_o = CLS_ERASE;
    else if (cmd_i <= RAM_TOP)  cls_o = CLS_RAM;
    else                        cls_o = CLS_NV;
  end
endmodule

// File: rtl/sdec_txn_fsm.sv
module sdec_txn_fsm
  import smbus_dec_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h34,
  parameter logic [7:0] RAM_TOP    = 8'hDF,
  parameter logic [7:0] ERASE_CMD  = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic       rx_ready_i,
  input  logic [7:0] rx_data_i,
  input  logic       erase_busy_i,
  input  logic       erase_en_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       erase_req_o,
  output logic       do_ptr_o,
  output logic       do_reg_o,
  output logic       do_nv_o,
  output logic [7:0] cmd_o,
  output logic [7:0] d0_o,
  output logic [7:0] d1_o
);
  txn_state_e state_q;
  logic [1:0] cnt_q;
  logic [7:0] cmd_q, d0_q, d1_q;
  cmd_class_e rx_cls, held_cls;
  logic       hs, addr_hit;
  logic [1:0] limit;

  sdec_classify #(.RAM_TOP(RAM_TOP), .ERASE_CMD(ERASE_CMD)) u_cls_rx (
    .cmd_i(rx_data_i), .cls_o(rx_cls));
  sdec_classify #(.RAM_TOP(RAM_TOP), .ERASE_CMD(ERASE_CMD)) u_cls_held (
    .cmd_i(cmd_q), .cls_o(held_cls));

  assign hs       = rx_valid_i && rx_ready_i;
  assign addr_hit = (rx_data_i[7:1] == SLAVE_ADDR) && !erase_busy_i;
  assign limit    = (held_cls == CLS_RAM) ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= 2'd0;
      cmd_q       <= 8'd0;
      d0_q        <= 8'd0;
      d1_q        <= 8'd0;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      erase_req_o <= 1'b0;
    end else begin
      ack_valid_o <= 1'b0;
      erase_req_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= 2'd0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else if (hs) begin
        ack_valid_o <= 1'b1;
        unique case (state_q)
          ST_ADDR: begin
            ack_o   <= addr_hit;
            state_q <= (addr_hit && !rx_data_i[0]) ? ST_CMD : ST_DROP;
          end
          ST_CMD: begin
            ack_o <= 1'b1;
            cmd_q <= rx_data_i;
            if (rx_cls == CLS_ERASE) begin
              state_q     <= ST_DROP;
              erase_req_o <= erase_en_i && !erase_busy_i;
            end else begin
              state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (cnt_q < limit) begin
              ack_o <= 1'b1;
              cnt_q <= cnt_q + 2'd1;
              if (cnt_q == 2'd0) d0_q <= rx_data_i;
              else               d1_q <= rx_data_i;
            end else begin
              ack_o   <= 1'b0;
              state_q <= ST_DROP;
            end
          end
          default: ack_o <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    do_ptr_o = 1'b0;
    do_reg_o = 1'b0;
    do_nv_o  = 1'b0;
    if (stop_i && !start_i && state_q == ST_DATA) begin
      do_ptr_o = (cnt_q == 2'd0);
      do_reg_o = (held_cls == CLS_RAM) && (cnt_q == 2'd1);
      do_nv_o  = (held_cls == CLS_NV)  && (cnt_q == 2'd2);
    end
  end

  assign cmd_o = cmd_q;
  assign d0_o  = d0_q;
  assign d1_o  = d1_q;
endmodule

// File: rtl/sdec_commit.sv
module sdec_commit #(
  parameter logic [7:0] CFG_ADDR     = 8'h90,
  parameter int         ERASE_EN_BIT = 2,
  parameter int         NV_AW        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_ptr_i,
  input  logic             do_reg_i,
  input  logic             do_nv_i,
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       d0_i,
  input  logic [7:0]       d1_i,
  input  logic             wr_ready_i,
  output logic             wr_valid_o,
  output logic [7:0]       wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic [7:0]       ptr_o,
  output logic [NV_AW-1:0] nv_ptr_o,
  output logic             erase_en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= 8'd0;
      wr_data_o  <= 8'd0;
      ptr_o      <= 8'd0;
      nv_ptr_o   <= '0;
      erase_en_o <= 1'b0;
    end else begin
      if (do_ptr_i) ptr_o <= cmd_i;
      if (do_nv_i)  nv_ptr_o <= NV_AW'({d0_i, d1_i});
      if (do_reg_i) begin
        wr_valid_o <= 1'b1;
        wr_addr_o  <= cmd_i;
        wr_data_o  <= d0_i;
        if (cmd_i == CFG_ADDR) erase_en_o <= d0_i[ERASE_EN_BIT];
      end else if (wr_valid_o && wr_ready_i) begin
        wr_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smbus_cmd_decoder.sv
module smbus_cmd_decoder
  import smbus_dec_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR   = 7'h34,
  parameter logic [7:0] RAM_TOP      = 8'hDF,
  parameter logic [7:0] ERASE_CMD    = 8'hFE,
  parameter logic [7:0] CFG_ADDR     = 8'h90,
  parameter int         ERASE_EN_BIT = 2,
  parameter int         NV_AW        = 16,
  parameter int         PAGE_LSB     = 5,
  parameter int         PAGE_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  input  logic              erase_busy_i,
  output logic              reg_wr_valid_o,
  input  logic              reg_wr_ready_i,
  output logic [7:0]        reg_wr_addr_o,
  output logic [7:0]        reg_wr_data_o,
  output logic [7:0]        ptr_o,
  output logic [NV_AW-1:0]  nv_ptr_o,
  output logic              erase_req_o,
  output logic [PAGE_W-1:0] erase_page_o
);
  logic       do_ptr, do_reg, do_nv, erase_en;
  logic [7:0] cmd, d0, d1;

  assign rx_ready_o = !reg_wr_valid_o;

  sdec_txn_fsm #(
    .SLAVE_ADDR(SLAVE_ADDR), .RAM_TOP(RAM_TOP), .ERASE_CMD(ERASE_CMD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_ready_i(rx_ready_o), .rx_data_i(rx_data_i),
    .erase_busy_i(erase_busy_i), .erase_en_i(erase_en),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .erase_req_o(erase_req_o),
    .do_ptr_o(do_ptr), .do_reg_o(do_reg), .do_nv_o(do_nv),
    .cmd_o(cmd), .d0_o(d0), .d1_o(d1)
  );

  sdec_commit #(
    .CFG_ADDR(CFG_ADDR), .ERASE_EN_BIT(ERASE_EN_BIT), .NV_AW(NV_AW)
  ) u_commit (
    .clk(clk), .rst_n(rst_n), .do_ptr_i(do_ptr), .do_reg_i(do_reg),
    .do_nv_i(do_nv), .cmd_i(cmd), .d0_i(d0), .d1_i(d1),
    .wr_ready_i(reg_wr_ready_i), .wr_valid_o(reg_wr_valid_o),
    .wr_addr_o(reg_wr_addr_o), .wr_data_o(reg_wr_data_o),
    .ptr_o(ptr_o), .nv_ptr_o(nv_ptr_o), .erase_en_o(erase_en)
  );

  assign erase_page_o = nv_ptr_o[PAGE_LSB +: PAGE_W];
endmodule

// File: rtl/smbus_cmd_decoder_chk.sv
module smbus_cmd_decoder_chk #(
  parameter logic [7:0] RAM_TOP   = 8'hDF,
  parameter logic [7:0] ERASE_CMD = 8'hFE
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_i,
  input logic       rx_valid_i,
  input logic       rx_ready_o,
  input logic [7:0] rx_data_i,
  input logic       ack_valid_o,
  input logic       erase_busy_i,
  input logic       reg_wr_valid_o,
  input logic       reg_wr_ready_i,
  input logic [7:0] reg_wr_addr_o,
  input logic [7:0] reg_wr_data_o,
  input logic [7:0] ptr_o,
  input logic       erase_req_o
);
  // R11
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(rx_valid_i && rx_ready_o));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid_o && !reg_wr_ready_i) |=>
      (reg_wr_valid_o && $stable(reg_wr_addr_o) && $stable(reg_wr_data_o)));

  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid_o |-> (reg_wr_addr_o <= RAM_TOP));

  // R4
  wr_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_valid_o) |-> $past(stop_i));

  // R6
  erase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |-> $past(rx_valid_i && rx_ready_o && !erase_busy_i &&
                          rx_data_i == ERASE_CMD));

  // R3
  ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_i) |-> $stable(ptr_o));
endmodule

bind smbus_cmd_decoder smbus_cmd_decoder_chk #(
  .RAM_TOP(RAM_TOP), .ERASE_CMD(ERASE_CMD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .rx_valid_i(rx_valid_i),
  .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i), .ack_valid_o(ack_valid_o),
  .erase_busy_i(erase_busy_i), .reg_wr_valid_o(reg_wr_valid_o),
  .reg_wr_ready_i(reg_wr_ready_i), .reg_wr_addr_o(reg_wr_addr_o),
  .reg_wr_data_o(reg_wr_data_o), .ptr_o(ptr_o), .erase_req_o(erase_req_o)
);

// File: tb/tb_smbus_cmd_decoder.sv
module tb_smbus_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, erase_busy_i = 0, reg_wr_ready_i = 1;
  logic [7:0] rx_data_i = 8'd0;
  logic rx_ready_o, ack_valid_o, ack_o, reg_wr_valid_o, erase_req_o;
  logic [7:0] reg_wr_addr_o, reg_wr_data_o, ptr_o;
  logic [15:0] nv_ptr_o;
  logic [4:0] erase_page_o;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  smbus_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .erase_busy_i(erase_busy_i),
    .reg_wr_valid_o(reg_wr_valid_o), .reg_wr_ready_i(reg_wr_ready_i),
    .reg_wr_addr_o(reg_wr_addr_o), .reg_wr_data_o(reg_wr_data_o),
    .ptr_o(ptr_o), .nv_ptr_o(nv_ptr_o), .erase_req_o(erase_req_o),
    .erase_page_o(erase_page_o)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [7:0]  cmd;
    logic [1:0]  n;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic [3:0]  acks;
    logic        wr;
    logic [7:0]  ptr;
    logic [15:0] nv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h68, 8'h10, 2'd1, 8'hA5, 8'h00, 4'b1110, 1'b1, 8'h00, 16'h0000},
    '{8'h68, 8'h90, 2'd1, 8'h04, 8'h00, 4'b1110, 1'b1, 8'h00, 16'h0000},
    '{8'h68, 8'h42, 2'd0, 8'h00, 8'h00, 4'b1100, 1'b0, 8'h42, 16'h0000},
    '{8'h68, 8'hF9, 2'd2, 8'hF9, 8'h45, 4'b1111, 1'b0, 8'h42, 16'hF945},
    '{8'h6A, 8'h10, 2'd1, 8'hA5, 8'h00, 4'b0000, 1'b0, 8'h42, 16'hF945},
    '{8'h68, 8'h20, 2'd2, 8'h11, 8'h22, 4'b1110, 1'b0, 8'h42, 16'hF945},
    '{8'h68, 8'hF8, 2'd1, 8'h12, 8'h00, 4'b1110, 1'b0, 8'h42, 16'hF945},
    '{8'h68, 8'hDF, 2'd1, 8'h3C, 8'h00, 4'b1110, 1'b1, 8'h42, 16'hF945}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = b;
    while (!rx_ready_o) @(negedge clk);
    @(negedge clk);
    rx_valid_i = 1'b0;
    check(ack_valid_o === 1'b1 && ack_o === exp_ack, tag,
          {ack_valid_o, ack_o}, {1'b1, exp_ack});
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!ack_valid_o && !erase_req_o && !reg_wr_valid_o && ptr_o == 0 && nv_ptr_o == 0
          && rx_ready_o, "R10 reset", {ptr_o, nv_ptr_o}, 0);

    // R7 erase disabled after reset
    pulse_start();
    send_byte(8'h68, 1'b1, "R1 addr");
    send_byte(8'hFE, 1'b1, "R11 erase cmd");
    check(erase_req_o == 1'b0, "R7 no erase while disabled", erase_req_o, 0);
    pulse_stop();

    for (int i = 0; i < NV; i++) begin
      pulse_start();
      send_byte(VECS[i].addr, VECS[i].acks[3], "R1 addr ack");
      send_byte(VECS[i].cmd,  VECS[i].acks[2], "R11 cmd ack");
      if (VECS[i].n >= 2'd1) send_byte(VECS[i].d0, VECS[i].acks[1], "R11/R8 data0 ack");
      if (VECS[i].n >= 2'd2) send_byte(VECS[i].d1, VECS[i].acks[0], "R11/R8 data1 ack");
      pulse_stop();
      check(reg_wr_valid_o == VECS[i].wr, "R4/R8 write issued", reg_wr_valid_o, VECS[i].wr);
      if (VECS[i].wr)
        check(reg_wr_addr_o == VECS[i].cmd && reg_wr_data_o == VECS[i].d0, "R4 write content",
              {reg_wr_addr_o, reg_wr_data_o}, {VECS[i].cmd, VECS[i].d0});
      check(ptr_o == VECS[i].ptr, "R3 pointer", ptr_o, VECS[i].ptr);
      check(nv_ptr_o == VECS[i].nv, "R5/R8 nv pointer", nv_ptr_o, VECS[i].nv);
    end

    // R6 erase with enable set, page from nv pointer 0xF945 -> bits 9:5 = 10
    pulse_start();
    send_byte(8'h68, 1'b1, "R1 addr");
    send_byte(8'hFE, 1'b1, "R6 erase cmd ack");
    check(erase_req_o == 1'b1 && erase_page_o == 5'd10, "R6 erase request",
          {erase_req_o, erase_page_o}, {1'b1, 5'd10});
    send_byte(8'h55, 1'b0, "R6 byte after erase nacked");
    check(erase_req_o == 1'b0, "R6 single pulse", erase_req_o, 0);
    pulse_stop();

    // R2 busy store: address nacked, rest ignored
    erase_busy_i = 1'b1;
    pulse_start();
    send_byte(8'h68, 1'b0, "R2 addr nack while busy");
    send_byte(8'h30, 1'b0, "R2 cmd ignored");
    send_byte(8'h99, 1'b0, "R2 data ignored");
    pulse_stop();
    check(reg_wr_valid_o == 1'b0, "R2 no write", reg_wr_valid_o, 0);
    erase_busy_i = 1'b0;

    // R7 clear enable via 0x90 bit 2 = 0, then erase does nothing
    pulse_start();
    send_byte(8'h68, 1'b1, "R1 addr");
    send_byte(8'h90, 1'b1, "R11 cmd");
    send_byte(8'hFB, 1'b1, "R11 data");
    pulse_stop();
    pulse_start();
    send_byte(8'h68, 1'b1, "R1 addr");
    send_byte(8'hFE, 1'b1, "R11 erase cmd");
    check(erase_req_o == 1'b0, "R7 erase disabled", erase_req_o, 0);
    pulse_stop();

    // R9 back-pressure on the register write
    reg_wr_ready_i = 1'b0;
    pulse_start();
    send_byte(8'h68, 1'b1, "R1 addr");
    send_byte(8'h33, 1'b1, "R11 cmd");
    send_byte(8'h77, 1'b1, "R11 data");
    pulse_stop();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(reg_wr_valid_o && !rx_ready_o && reg_wr_addr_o == 8'h33 && reg_wr_data_o == 8'h77,
            "R9 hold under stall", {reg_wr_valid_o, rx_ready_o, reg_wr_addr_o, reg_wr_data_o},
            {1'b1, 1'b0, 8'h33, 8'h77});
    end
    reg_wr_ready_i = 1'b1;
    @(negedge clk);
    check(!reg_wr_valid_o && rx_ready_o, "R9 release", {reg_wr_valid_o, rx_ready_o}, 2'b01);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule